// File: doc/BRIEF.md
# Interrupt Controller Command-Word Front End

This block is the programming front end of an eight-input interrupt controller. Software reaches it through a byte-wide bus with a one-bit address and separate write and read strobes. Address 0 is the command port and address 1 is the data port. After reset the block runs a short initialization sequence. A mode word on the command port starts it. Data-port writes then supply a vector base, an optional cascade word and an optional extension word. Which of the optional words are expected depends on control bits in the mode word.

Once programming is complete the block raises a ready flag. From then on, data-port writes load the interrupt mask. Command-port writes are decoded by bit pattern. One class produces end-of-interrupt pulses. The other class chooses which status register a command-port read returns: the request register or the in-service register, both supplied by the interrupt core. The stored configuration bytes, the mask and the end-of-interrupt pulses go to that core.

Top module: `irqc_cmd_front`

## Requirements
- R1: After reset the ready flag is low, the mask and all configuration outputs are zero, no end-of-interrupt pulse is active, and a command-port read returns the request register.
- R2: A command-port write with bit 4 set is taken as the mode word from any state. It is stored on the mode output, the ready flag drops, and the next data-port write is taken as the vector base.
- R3: The data-port write that follows the mode word is stored as the vector base. If mode bit 1 (single) is 0, the next data-port write is stored as the cascade word.
- R4: If mode bit 1 is 1, the vector base is followed by the extension word when mode bit 0 is 1. When mode bit 0 is 0, the block goes straight to ready.
- R5: After the cascade word, the extension word is expected if mode bit 0 is 1; otherwise the block is ready. The extension word always leads to ready. The ready flag is high only in the ready state.
- R6: In the ready state a data-port write loads the mask; in any other state it leaves the mask unchanged. A data-port read returns the mask.
- R7: In the ready state, a command write with bits 4:3 = 00, bit 5 = 1, bit 7 = 0 and bit 6 = 1 produces a one-cycle specific end-of-interrupt pulse. Bits 2:0 of that write appear on the level output.
- R8: The same write with bit 6 = 0 produces a one-cycle non-specific pulse. When bit 7 = 1 or bit 5 = 0, no pulse is produced. The two pulses are never high together.
- R9: In the ready state, a command write with bits 4:3 = 01 stores its bits 1:0 as the read select. A select of 11 makes command-port reads return the in-service register; 10, 01 and 00 return the request register.
- R10: Command-port writes with bit 4 clear that arrive before the ready state are ignored. They produce no pulse and leave the sequence position unchanged.
- R11: Read data is registered. It is updated on the clock edge that samples the read strobe, one cycle after the strobe, and holds its value while no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 = command port, 1 = data port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| req_reg_i | input | 8 | Request register from the interrupt core |
| insvc_reg_i | input | 8 | In-service register from the interrupt core |
| cfg_mode_o | output | 8 | Stored mode word |
| cfg_vbase_o | output | 8 | Stored vector base |
| cfg_cascade_o | output | 8 | Stored cascade word |
| cfg_ext_o | output | 8 | Stored extension word |
| mask_o | output | 8 | Interrupt mask |
| eoi_spec_o | output | 1 | Specific end-of-interrupt pulse |
| eoi_nonspec_o | output | 1 | Non-specific end-of-interrupt pulse |
| eoi_level_o | output | 3 | Level of the last specific end-of-interrupt |
| ready_o | output | 1 | Programming complete |

## Verification
The bench builds the block with its defaults: an 8-bit data width, a 3-bit level field and read select reset to 10. With these values every decoded bit position of the command words lies inside the bus. The bench drives all four paths through the initialization sequence that the single and extension bits allow, plus a restart in the middle of a sequence. It exercises each read-select code, and each end-of-interrupt variant together with its suppressed forms.

// File: rtl/irqc_cmd_pkg.sv
package irqc_cmd_pkg;

  typedef enum logic [2:0] {
    SQ_WAIT_MODE,
    SQ_WAIT_VBASE,
    SQ_WAIT_CASC,
    SQ_WAIT_EXT,
    SQ_READY
  } seq_e;

  // bit positions decoded in command and mode words
  localparam int unsigned B_EXT_REQ = 0;
  localparam int unsigned B_SINGLE  = 1;
  localparam int unsigned B_CLASS   = 3;
  localparam int unsigned B_INIT    = 4;
  localparam int unsigned B_EOI     = 5;
  localparam int unsigned B_SPEC    = 6;
  localparam int unsigned B_ROT     = 7;

  localparam logic [1:0] RDSEL_INSVC = 2'b11;

endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_cmd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          dat_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] vbase_q,
  output logic [DW-1:0] casc_q,
  output logic [DW-1:0] ext_q,
  output logic          ready
);

  seq_e state_q, state_d;
  logic mode_en, vbase_en, casc_en, ext_en;
  logic is_mode;

  assign is_mode = cmd_wr && wdata[B_INIT];

  always_comb begin
    state_d  = state_q;
    mode_en  = 1'b0;
    vbase_en = 1'b0;
    casc_en  = 1'b0;
    ext_en   = 1'b0;
    if (is_mode) begin
      mode_en = 1'b1;
      state_d = SQ_WAIT_VBASE;
    end else if (dat_wr) begin
      case (state_q)
        SQ_WAIT_VBASE: begin
          vbase_en = 1'b1;
          if (!mode_q[B_SINGLE])      state_d = SQ_WAIT_CASC;
          else if (mode_q[B_EXT_REQ]) state_d = SQ_WAIT_EXT;
          else                        state_d = SQ_READY;
        end
        SQ_WAIT_CASC: begin
          casc_en = 1'b1;
          state_d = mode_q[B_EXT_REQ] ? SQ_WAIT_EXT : SQ_READY;
        end
        SQ_WAIT_EXT: begin
          ext_en  = 1'b1;
          state_d = SQ_READY;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_WAIT_MODE;
      mode_q  <= '0;
      vbase_q <= '0;
      casc_q  <= '0;
      ext_q   <= '0;
    end else begin
      state_q <= state_d;
      if (mode_en)  mode_q  <= wdata;
      if (vbase_en) vbase_q <= wdata;
      if (casc_en)  casc_q  <= wdata;
      if (ext_en)   ext_q   <= wdata;
    end
  end

  assign ready = (state_q == SQ_READY);

  assert_mode_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_mode |=> (state_q == SQ_WAIT_VBASE) && !ready);

  assert_ready_by_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(dat_wr));

  assert_vbase_only_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |=> $stable(vbase_q));

endmodule

// File: rtl/irqc_opword_dec.sv
module irqc_opword_dec
  import irqc_cmd_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter logic [1:0]  RDSEL_RESET = 2'b10,
  localparam int unsigned LVL_W      = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             ready,
  input  logic [DW-1:0]    wdata,
  output logic             eoi_spec,
  output logic             eoi_nonspec,
  output logic [LVL_W-1:0] eoi_level,
  output logic [1:0]       rdsel
);

  logic ow_wr, is_ow2, is_ow3;
  logic eoi_ok, spec_d, ns_d;

  assign ow_wr  = cmd_wr && ready && !wdata[B_INIT];
  assign is_ow2 = ow_wr && !wdata[B_CLASS];
  assign is_ow3 = ow_wr &&  wdata[B_CLASS];
  assign eoi_ok = is_ow2 && wdata[B_EOI] && !wdata[B_ROT];

  always_comb begin
    spec_d = eoi_ok &&  wdata[B_SPEC];
    ns_d   = eoi_ok && !wdata[B_SPEC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_spec    <= 1'b0;
      eoi_nonspec <= 1'b0;
      eoi_level   <= '0;
      rdsel       <= RDSEL_RESET;
    end else begin
      eoi_spec    <= spec_d;
      eoi_nonspec <= ns_d;
      if (spec_d) eoi_level <= wdata[LVL_W-1:0];
      if (is_ow3) rdsel     <= wdata[1:0];
    end
  end

  assert_eoi_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eoi_spec, eoi_nonspec}));

  assert_eoi_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_spec || eoi_nonspec) |-> $past(cmd_wr && ready));

  assert_rdsel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && ready) |=> $stable(rdsel));

endmodule

// File: rtl/irqc_rd_path.sv
module irqc_rd_path
  import irqc_cmd_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dat_wr,
  input  logic          ready,
  input  logic          rd,
  input  logic          addr,
  input  logic [1:0]    rdsel,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] req_reg,
  input  logic [DW-1:0] insvc_reg,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] rdata_q
);

  logic [DW-1:0] rd_sel;
  logic          mask_en;

  assign mask_en = dat_wr && ready;

  always_comb begin
    if (addr)                      rd_sel = mask_q;
    else if (rdsel == RDSEL_INSVC) rd_sel = insvc_reg;
    else                           rd_sel = req_reg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (mask_en) mask_q  <= wdata;
      if (rd)      rdata_q <= rd_sel;
    end
  end

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dat_wr && ready) |=> $stable(mask_q));

  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata_q));

endmodule

// File: rtl/irqc_cmd_front.sv
module irqc_cmd_front
  import irqc_cmd_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter logic [1:0]  RDSEL_RESET = 2'b10,
  localparam int unsigned LVL_W      = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [DW-1:0]    req_reg_i,
  input  logic [DW-1:0]    insvc_reg_i,
  output logic [DW-1:0]    cfg_mode_o,
  output logic [DW-1:0]    cfg_vbase_o,
  output logic [DW-1:0]    cfg_cascade_o,
  output logic [DW-1:0]    cfg_ext_o,
  output logic [DW-1:0]    mask_o,
  output logic             eoi_spec_o,
  output logic             eoi_nonspec_o,
  output logic [LVL_W-1:0] eoi_level_o,
  output logic             ready_o
);

  logic       cmd_wr, dat_wr, ready;
  logic [1:0] rdsel;

  assign cmd_wr = bus_wr && !bus_addr;
  assign dat_wr = bus_wr &&  bus_addr;

  irqc_init_seq #(.DW(DW)) i_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (cmd_wr),
    .dat_wr  (dat_wr),
    .wdata   (bus_wdata),
    .mode_q  (cfg_mode_o),
    .vbase_q (cfg_vbase_o),
    .casc_q  (cfg_cascade_o),
    .ext_q   (cfg_ext_o),
    .ready   (ready)
  );

  irqc_opword_dec #(.DW(DW), .RDSEL_RESET(RDSEL_RESET)) i_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr      (cmd_wr),
    .ready       (ready),
    .wdata       (bus_wdata),
    .eoi_spec    (eoi_spec_o),
    .eoi_nonspec (eoi_nonspec_o),
    .eoi_level   (eoi_level_o),
    .rdsel       (rdsel)
  );

  irqc_rd_path #(.DW(DW)) i_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .dat_wr    (dat_wr),
    .ready     (ready),
    .rd        (bus_rd),
    .addr      (bus_addr),
    .rdsel     (rdsel),
    .wdata     (bus_wdata),
    .req_reg   (req_reg_i),
    .insvc_reg (insvc_reg_i),
    .mask_q    (mask_o),
    .rdata_q   (bus_rdata)
  );

  assign ready_o = ready;

  assert_no_pulse_in_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !ready && !bus_wdata[B_INIT]) |=> !eoi_spec_o && !eoi_nonspec_o && !ready_o);

endmodule

// File: tb/test_irqc_cmd_front.sv
module test_irqc_cmd_front;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_addr, bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata, req_reg_i, insvc_reg_i;
  logic [7:0] cfg_mode_o, cfg_vbase_o, cfg_cascade_o, cfg_ext_o, mask_o;
  logic       eoi_spec_o, eoi_nonspec_o, ready_o;
  logic [2:0] eoi_level_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  typedef struct packed { logic spec; logic ns; logic [2:0] lvl; } eoi_t;
  eoi_t       eoi_q[$];
  logic [7:0] rd_q[$];
  string      rd_tag[$];
  logic       rd_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_cmd_front i_irqc_cmd_front (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .req_reg_i(req_reg_i),
    .insvc_reg_i(insvc_reg_i), .cfg_mode_o(cfg_mode_o), .cfg_vbase_o(cfg_vbase_o),
    .cfg_cascade_o(cfg_cascade_o), .cfg_ext_o(cfg_ext_o), .mask_o(mask_o),
    .eoi_spec_o(eoi_spec_o), .eoi_nonspec_o(eoi_nonspec_o), .eoi_level_o(eoi_level_o),
    .ready_o(ready_o)
  );

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // driver: one write, returns at the negedge after the capturing edge
  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wr_eoi(logic [7:0] d, logic spec, logic ns, logic [2:0] lvl);
    eoi_q.push_back('{spec: spec, ns: ns, lvl: lvl});
    wr(1'b0, d);
  endtask

  task automatic rd(logic a, logic [7:0] exp, string req);
    rd_q.push_back(exp);
    rd_tag.push_back(req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: compares produced results against queued expectations
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rd_seen === 1'b1) begin
        if (rd_q.size() == 0) begin
          n_checks++; n_errors++;
          $display("FAIL R11: unexpected read result got %h expected none", bus_rdata);
        end else begin
          check(rd_tag.pop_front(), bus_rdata, rd_q.pop_front());
        end
      end
      if (eoi_spec_o || eoi_nonspec_o) begin
        if (eoi_q.size() == 0) begin
          n_checks++; n_errors++;
          $display("FAIL R8: unexpected pulse got spec=%b ns=%b expected none",
                   eoi_spec_o, eoi_nonspec_o);
        end else begin
          eoi_t e;
          e = eoi_q.pop_front();
          check("R7", {6'd0, eoi_spec_o, eoi_nonspec_o}, {6'd0, e.spec, e.ns});
          if (e.spec) check("R7", {5'd0, eoi_level_o}, {5'd0, e.lvl});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    req_reg_i = 8'h5A; insvc_reg_i = 8'hC3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1", {7'd0, ready_o}, 8'h00);
    check("R1", mask_o, 8'h00);
    check("R1", cfg_mode_o | cfg_vbase_o | cfg_cascade_o | cfg_ext_o, 8'h00);
    check("R1", {6'd0, eoi_spec_o, eoi_nonspec_o}, 8'h00);
    rd(1'b0, 8'h5A, "R1");
    rd(1'b1, 8'h00, "R6");
    // R10 command word before mode word
    wr(1'b0, 8'h20);
    check("R10", {6'd0, eoi_spec_o, eoi_nonspec_o}, 8'h00);
    check("R10", {7'd0, ready_o}, 8'h00);
    // single, no extension
    wr(1'b0, 8'h12);
    check("R2", cfg_mode_o, 8'h12);
    check("R2", {7'd0, ready_o}, 8'h00);
    wr(1'b1, 8'h40);
    check("R3", cfg_vbase_o, 8'h40);
    check("R4", {7'd0, ready_o}, 8'h01);
    // mask
    wr(1'b1, 8'hA5);
    check("R6", mask_o, 8'hA5);
    rd(1'b1, 8'hA5, "R6");
    // end-of-interrupt words
    wr_eoi(8'h63, 1'b1, 1'b0, 3'd3);
    check("R7", {5'd0, eoi_level_o}, 8'h03);
    wr_eoi(8'h65, 1'b1, 1'b0, 3'd5);
    wr_eoi(8'h20, 1'b0, 1'b1, 3'd0);
    wr(1'b0, 8'hE0);
    check("R8", {6'd0, eoi_spec_o, eoi_nonspec_o}, 8'h00);
    wr(1'b0, 8'h40);
    check("R8", {6'd0, eoi_spec_o, eoi_nonspec_o}, 8'h00);
    check("R8", {5'd0, eoi_level_o}, 8'h05);
    // read select
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'hC3, "R9");
    req_reg_i = 8'h3C;
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h3C, "R9");
    wr(1'b0, 8'h08);
    rd(1'b0, 8'h3C, "R9");
    wr(1'b0, 8'h09);
    rd(1'b0, 8'h3C, "R9");
    // cascade + extension
    wr(1'b0, 8'h11);
    check("R2", {7'd0, ready_o}, 8'h00);
    wr(1'b1, 8'h70);
    check("R3", cfg_vbase_o, 8'h70);
    check("R3", {7'd0, ready_o}, 8'h00);
    wr(1'b0, 8'h20);
    check("R10", {6'd0, eoi_spec_o, eoi_nonspec_o}, 8'h00);
    wr(1'b1, 8'h04);
    check("R3", cfg_cascade_o, 8'h04);
    check("R5", {7'd0, ready_o}, 8'h00);
    check("R6", mask_o, 8'hA5);
    wr(1'b1, 8'h1D);
    check("R5", cfg_ext_o, 8'h1D);
    check("R5", {7'd0, ready_o}, 8'h01);
    // cascade, no extension
    wr(1'b0, 8'h10);
    wr(1'b1, 8'h08);
    wr(1'b1, 8'h02);
    check("R5", cfg_cascade_o, 8'h02);
    check("R5", {7'd0, ready_o}, 8'h01);
    check("R5", cfg_ext_o, 8'h1D);
    // single + extension
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h20);
    check("R4", {7'd0, ready_o}, 8'h00);
    wr(1'b1, 8'h03);
    check("R4", cfg_ext_o, 8'h03);
    check("R4", {7'd0, ready_o}, 8'h01);
    // restart in mid sequence
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h50);
    wr(1'b0, 8'h12);
    check("R2", cfg_mode_o, 8'h12);
    check("R2", {7'd0, ready_o}, 8'h00);
    wr(1'b1, 8'h60);
    check("R2", cfg_vbase_o, 8'h60);
    check("R2", {7'd0, ready_o}, 8'h01);
    // registered read data holds
    rd(1'b0, 8'h3C, "R11");
    req_reg_i = 8'hFF;
    repeat (3) @(negedge clk);
    check("R11", bus_rdata, 8'h3C);
    repeat (2) @(negedge clk);
    check("R7", 8'(eoi_q.size()), 8'h00);
    check("R11", 8'(rd_q.size()), 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule